// File: doc/BRIEF.md
# Monochrome Bitmap Pixel Expander

This block paints a one-bit-per-pixel glyph or stipple into an 8-bit-per-pixel framebuffer. Software loads two rectangle corners, a 32-bit pattern word and an ink colour through a small register write port, then writes a go register. The engine sorts the corners, walks the rectangle row by row, and takes one pattern bit for each pixel position, starting at the top bit. Set bits emit a one-byte store of the ink colour to the framebuffer. Clear bits leave memory alone.

A rectangle no wider than sixteen pixels has its pattern moved up by sixteen bit places before the walk begins, so a narrow glyph row draws from the low half of the word. Positions outside the 1280 by 1024 visible area still use up a pattern bit but produce no store. When all 32 bits have been used, every remaining position is skipped, and the walk still runs to the last row.

Top module: `mpx_expand`

## Requirements
- R1: A register write with `cfg_addr` 0x2070 loads corner A and 0x2074 loads corner B, taking X from data bits 27:16 and Y from bits 11:0. A write to 0x20c4 loads the 32-bit pattern, and a write to 0x20d0 loads the colour. Each store carries the low 8 bits of the colour as `mem_data`.
- R2: The corners are sorted per axis before use. x1 is the smaller X and x2 the larger, and y1 and y2 are sorted the same way, so swapped corners cover the same rectangle.
- R3: When x2 - x1 is 15 or less, the pattern is shifted left by 16 before the walk. Otherwise it is used as written.
- R4: Positions are visited in raster order. X runs from x1 to x2, then returns to x1 while Y increments, and the walk ends after the position (x2, y2). Pixel i uses pattern bit 31 - i, and any pixel past the 32nd uses a zero bit.
- R5: A store is issued only for a position whose pattern bit is 1. A 0 bit produces no store.
- R6: The store address is 0x38000000 + x + 1280*y.
- R7: A position with x >= 1280 or y >= 1024 produces no store, but it still uses its pattern bit.
- R8: While `mem_ready` is high, one position is visited per clock. `busy` rises on the clock edge that takes the go write and stays high for exactly W*H cycles.
- R9: While `mem_valid` is high and `mem_ready` is low, the walk stalls, and `mem_addr` and `mem_data` hold their values.
- R10: A go write while `busy` is high is ignored. Writes to corner, pattern or colour registers during a walk do not change the walk in progress, but the next walk uses them.
- R11: After reset `busy` and `mem_valid` are low and all registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 14 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| busy | output | 1 | Walk in progress |
| mem_valid | output | 1 | Pixel store request |
| mem_ready | input | 1 | Store accepted this cycle |
| mem_addr | output | 32 | Framebuffer byte address |
| mem_data | output | 8 | Pixel colour byte |

## Verification
Register writes and the pixel walk can happen in the same cycle. The bench tests this by writing a new pattern, a new colour and a second go while a walk is stalling on a random `mem_ready`. The first walk's store list must match the values latched at its own go. A following walk must then show the new pattern. Other runs sweep rectangle widths from 1 to 20 across the narrow-shift threshold, use swapped corners, and straddle the right and bottom edges of the visible area. Each run is compared store by store, and with `mem_ready` held high the duration of `busy` is counted as well.

// File: rtl/mpx_pkg.sv
package mpx_pkg;
    localparam int unsigned COORD_W = 12;

    typedef struct packed {
        logic [COORD_W-1:0] x;
        logic [COORD_W-1:0] y;
    } point_t;

    localparam logic [13:0] OFS_CORNER_A = 14'h2070;
    localparam logic [13:0] OFS_CORNER_B = 14'h2074;
    localparam logic [13:0] OFS_PATTERN  = 14'h20c4;
    localparam logic [13:0] OFS_INK      = 14'h20d0;
    localparam logic [13:0] OFS_GO       = 14'h29f0;
endpackage

// File: rtl/mpx_sort.sv
module mpx_sort
    import mpx_pkg::*;
(
    input  point_t a,
    input  point_t b,
    output point_t lo,
    output point_t hi
);
    always_comb begin
        lo.x = (b.x < a.x) ? b.x : a.x;
        hi.x = (b.x < a.x) ? a.x : b.x;
        lo.y = (b.y < a.y) ? b.y : a.y;
        hi.y = (b.y < a.y) ? a.y : b.y;
    end
endmodule

// File: rtl/mpx_align.sv
module mpx_align
    import mpx_pkg::*;
#(
    parameter int unsigned PAT_W       = 32,
    parameter int unsigned NARROW_SPAN = 15
) (
    input  logic [COORD_W-1:0] span,
    input  logic [PAT_W-1:0]   pat_in,
    output logic [PAT_W-1:0]   pat_out
);
    localparam int unsigned HALF = PAT_W / 2;

    logic narrow;
    always_comb begin
        narrow  = (span <= COORD_W'(NARROW_SPAN));
        pat_out = narrow ? (pat_in << HALF) : pat_in;
    end
endmodule

// File: rtl/mpx_addr.sv
module mpx_addr
    import mpx_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned FB_W    = 1280,
    parameter int unsigned FB_H    = 1024,
    parameter logic [ADDR_W-1:0] FB_BASE = 32'h3800_0000
) (
    input  logic [COORD_W-1:0] x,
    input  logic [COORD_W-1:0] y,
    output logic [ADDR_W-1:0]  addr,
    output logic               in_frame
);
    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(FB_W);

    always_comb begin
        addr     = FB_BASE + ADDR_W'(x) + ADDR_W'(y) * STRIDE;
        in_frame = (32'(x) < FB_W) && (32'(y) < FB_H);
    end
endmodule

// File: rtl/mpx_expand.sv
module mpx_expand
    import mpx_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned FB_W        = 1280,
    parameter int unsigned FB_H        = 1024,
    parameter logic [ADDR_W-1:0] FB_BASE = 32'h3800_0000,
    parameter int unsigned PAT_W       = 32,
    parameter int unsigned NARROW_SPAN = 15,
    parameter int unsigned REG_AW      = 14,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned PIX_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              busy,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [PIX_W-1:0]  mem_data
);
    localparam int unsigned XF_LSB = 16;
    localparam logic [ADDR_W-1:0] FB_END = FB_BASE + ADDR_W'(FB_W * FB_H);

    typedef struct packed {
        point_t             corner_a;
        point_t             corner_b;
        logic [PAT_W-1:0]   pattern;
        logic [PIX_W-1:0]   colour;
        logic               run;
        point_t             lo;
        point_t             hi;
        logic [COORD_W-1:0] x;
        logic [COORD_W-1:0] y;
        logic [PAT_W-1:0]   shreg;
        logic [PIX_W-1:0]   ink;
    } state_t;

    state_t st_q, st_d;

    point_t           sort_lo, sort_hi;
    logic [PAT_W-1:0] aligned;
    logic [ADDR_W-1:0] pix_addr;
    logic             in_frame;
    logic             want, advance;
    point_t           wr_point;

    mpx_sort u_sort (
        .a  (st_q.corner_a),
        .b  (st_q.corner_b),
        .lo (sort_lo),
        .hi (sort_hi)
    );

    mpx_align #(.PAT_W(PAT_W), .NARROW_SPAN(NARROW_SPAN)) u_align (
        .span    (sort_hi.x - sort_lo.x),
        .pat_in  (st_q.pattern),
        .pat_out (aligned)
    );

    mpx_addr #(.ADDR_W(ADDR_W), .FB_W(FB_W), .FB_H(FB_H), .FB_BASE(FB_BASE)) u_addr (
        .x        (st_q.x),
        .y        (st_q.y),
        .addr     (pix_addr),
        .in_frame (in_frame)
    );

    always_comb begin
        st_d       = st_q;
        wr_point.x = cfg_wdata[XF_LSB +: COORD_W];
        wr_point.y = cfg_wdata[0 +: COORD_W];
        want       = st_q.run && st_q.shreg[PAT_W-1] && in_frame;
        advance    = st_q.run && (!want || mem_ready);

        if (cfg_we) begin
            if (cfg_addr == REG_AW'(OFS_CORNER_A)) st_d.corner_a = wr_point;
            if (cfg_addr == REG_AW'(OFS_CORNER_B)) st_d.corner_b = wr_point;
            if (cfg_addr == REG_AW'(OFS_PATTERN))  st_d.pattern  = cfg_wdata[PAT_W-1:0];
            if (cfg_addr == REG_AW'(OFS_INK))      st_d.colour   = cfg_wdata[PIX_W-1:0];
            if (cfg_addr == REG_AW'(OFS_GO) && !st_q.run) begin
                st_d.run   = 1'b1;
                st_d.lo    = sort_lo;
                st_d.hi    = sort_hi;
                st_d.x     = sort_lo.x;
                st_d.y     = sort_lo.y;
                st_d.shreg = aligned;
                st_d.ink   = st_q.colour;
            end
        end

        if (advance) begin
            st_d.shreg = st_q.shreg << 1;
            if (st_q.x == st_q.hi.x) begin
                st_d.x = st_q.lo.x;
                if (st_q.y == st_q.hi.y) st_d.run = 1'b0;
                else                     st_d.y   = st_q.y + 1'b1;
            end else begin
                st_d.x = st_q.x + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy      = st_q.run;
    assign mem_valid = want;
    assign mem_addr  = pix_addr;
    assign mem_data  = st_q.ink;

    AST_STORE_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> busy); // R5
    AST_STORE_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_addr >= FB_BASE && mem_addr < FB_END)); // R7
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data))); // R9
    AST_X_WITHIN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> (st_q.x >= st_q.lo.x && st_q.x <= st_q.hi.x)); // R4
    AST_Y_WITHIN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> (st_q.y >= st_q.lo.y && st_q.y <= st_q.hi.y)); // R4
    AST_INK_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |=> (!st_q.run || $stable(st_q.ink))); // R10
endmodule

// File: tb/mpx_expand_tb.sv
`timescale 1ns/1ps
module mpx_expand_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [13:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        busy, mem_valid, mem_ready;
    logic [31:0] mem_addr;
    logic [7:0]  mem_data;

    always #2 clk = ~clk;

    mpx_expand u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .busy(busy), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit rnd_ready = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    logic [31:0] got_addr [64];
    logic [7:0]  got_dat  [64];
    int          got_n = 0;
    logic [31:0] exp_addr [64];
    int          exp_n = 0;
    int          exp_pix = 0;

    initial mem_ready = 1'b1;

    always @(negedge clk) begin
        cycles++;
        lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_ready <= rnd_ready ? (lfsr[0] | lfsr[3]) : 1'b1;
        #1;
        if (mem_valid && mem_ready) begin
            if (got_n < 64) begin
                got_addr[got_n] = mem_addr;
                got_dat[got_n]  = mem_data;
            end
            got_n++;
        end
        if (cycles > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog act=%0d exp=<150000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
        end
    endtask

    task automatic wr(input logic [13:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Model of R2, R3, R4, R5, R6, R7 written from the requirement text
    task automatic build_exp(input int ax, input int ay, input int bx, input int by,
                             input logic [31:0] pat);
        int x1 = (ax < bx) ? ax : bx;
        int x2 = (ax < bx) ? bx : ax;
        int y1 = (ay < by) ? ay : by;
        int y2 = (ay < by) ? by : ay;
        int w = x2 - x1 + 1;
        int h = y2 - y1 + 1;
        logic [31:0] p = (x2 - x1 <= 15) ? (pat << 16) : pat;
        exp_n = 0;
        exp_pix = w * h;
        for (int i = 0; i < w * h; i++) begin
            int x = x1 + i % w;
            int y = y1 + i / w;
            bit b = (i < 32) ? p[31 - i] : 1'b0;
            if (b && x < 1280 && y < 1024) begin
                if (exp_n < 64) exp_addr[exp_n] = 32'h3800_0000 + 32'(x) + 32'(y) * 32'd1280;
                exp_n++;
            end
        end
    endtask

    task automatic compare(input string tag, input logic [7:0] col);
        chk(got_n == exp_n, {tag, " store count R4 R5 R7"}, got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n && i < 64; i++) begin
            chk(got_addr[i] == exp_addr[i], {tag, " address R6"}, got_addr[i], exp_addr[i]);
            chk(got_dat[i] == col, {tag, " colour R1"}, got_dat[i], col);
        end
    endtask

    task automatic wait_idle(output int busy_cyc);
        busy_cyc = 0;
        while (busy && busy_cyc < 5000) begin
            busy_cyc++;
            @(negedge clk);
        end
    endtask

    task automatic run_case(input string tag, input int ax, input int ay, input int bx,
                            input int by, input logic [31:0] pat, input logic [31:0] colw,
                            input bit rnd, input bit disturb);
        int bc;
        rnd_ready = rnd;
        wr(14'h2070, {4'h0, 12'(ax), 4'h0, 12'(ay)});
        wr(14'h2074, {4'h0, 12'(bx), 4'h0, 12'(by)});
        wr(14'h20c4, pat);
        wr(14'h20d0, colw);
        build_exp(ax, ay, bx, by, pat);
        got_n = 0;
        wr(14'h29f0, 32'h1);
        if (disturb) begin
            // R10: register writes and a second go while the walk runs
            wr(14'h20c4, ~pat);
            wr(14'h20d0, 32'h0000_0033);
            wr(14'h29f0, 32'h1);
        end
        wait_idle(bc);
        if (!rnd && !disturb)
            chk(bc == exp_pix, {tag, " busy length R8"}, bc, exp_pix);
        compare(tag, colw[7:0]);
        rnd_ready = 1'b0;
    endtask

    initial begin
        int bc;
        #1;
        @(negedge clk);
        chk(busy == 1'b0, "R11 busy after reset", busy, 0);
        chk(mem_valid == 1'b0, "R11 mem_valid after reset", mem_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && mem_valid == 1'b0, "R11 idle after release", {busy, mem_valid}, 0);

        run_case("R3 narrow16",   10, 5, 25, 6, 32'h0000_A5C3, 32'h1234_56AB, 1'b0, 1'b0);
        run_case("R3 wide17",    100, 200, 116, 201, 32'hF00F_1234, 32'h0000_0077, 1'b1, 1'b0);
        run_case("R2 swapped",    40, 30, 33, 28, 32'h0000_1234, 32'h0000_00C5, 1'b0, 1'b0);
        run_case("R7 edge clip", 1270, 1020, 1289, 1027, 32'hFFFF_FFFF, 32'h0000_00E1, 1'b0, 1'b0);
        run_case("R3 one pixel",   0, 0, 0, 0, 32'h0000_8000, 32'h0000_0011, 1'b0, 1'b0);
        run_case("R3 one lost",    0, 0, 0, 0, 32'h8000_0000, 32'h0000_0011, 1'b0, 1'b0);
        run_case("R9 stall",      50, 60, 70, 63, 32'hDEAD_BEEF, 32'h0000_009A, 1'b1, 1'b0);
        run_case("R10 busy go",   50, 60, 70, 63, 32'hC3C3_5A5A, 32'h0000_004E, 1'b1, 1'b1);
        // R10: registers written during the previous walk are used by the next one
        build_exp(50, 60, 70, 63, ~32'hC3C3_5A5A);
        got_n = 0;
        wr(14'h29f0, 32'h1);
        wait_idle(bc);
        compare("R10 next walk", 8'h33);

        // R3 R4 R8: sweep widths across the narrow threshold
        for (int w = 1; w <= 20; w++)
            run_case("R4 width sweep", 300, 400, 300 + w - 1, 401, 32'h9249_B6DB,
                     32'h0000_0000 | w, 1'b0, 1'b0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule